// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits between instruction memory and a variable-length instruction decoder. It holds up to fifteen instruction bytes, which is the longest instruction the decoder can meet. Every cycle it shows those bytes to the decoder as a window aligned to position zero, together with a per-byte valid mask and the address of the first byte. When the decoder has sized the instruction at the head, it returns a byte count. In the next cycle those bytes are gone, the leftover bytes sit at position zero, and the head address has moved forward by the same count.

Refill uses a memory-side port that returns four-byte chunks in request order. The queue asks for a chunk only when its current bytes, plus every chunk still owed on the current path, plus the new chunk all fit in the fifteen slots. Because of this reservation, a response can always be written whole, and a refill can land in the same cycle as a consume.

A taken jump or return drives the redirect input with the target address. The buffer empties at once and fetching restarts at the target. Any chunks still on their way for the abandoned path are counted and discarded when they arrive. A redirect wins over a consume or a refill in the same cycle.

Top module: `instr_prefetch_queue`

## Requirements
- R1: After reset the window is empty (valid mask all zero), the head address equals the RESET_ADDR parameter, and the first request carries RESET_ADDR.
- R2: Window byte k (bits 8k+7..8k) holds the memory byte at head address + k for every k below the occupancy. The valid mask has exactly the low occupancy bits set, and every byte position at or above the occupancy reads zero.
- R3: A consume count n removes the n oldest bytes, moves the rest down to position zero in their original order, and advances the head address by n.
- R4: A consume count larger than the occupancy removes only the bytes present. The head address advances by the occupancy.
- R5: In a cycle without redirect, the next occupancy equals occupancy − bytes removed + 4 when a response for the current path arrives, and occupancy − bytes removed otherwise.
- R6: A request is raised only when no redirect is present, occupancy + 4 × (current-path chunks outstanding + 1) ≤ 15, and total outstanding chunks (both paths) < MAX_OUT. Consecutive accepted requests carry addresses that rise by 4.
- R7: A request that is not accepted stays raised with the same address in the next cycle, unless a redirect intervenes.
- R8: A redirect leaves the buffer empty with head address equal to the target in the next cycle. This holds whatever consume or response came with it. No request is raised in the redirect cycle, and the next request carries the target address.
- R9: Responses to requests accepted before a redirect are discarded, including one that arrives in the redirect cycle itself. They never change occupancy or window contents.
- R10: Occupancy never exceeds 15, and occupancy plus the reserved space for outstanding current-path chunks never exceeds 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect_i | input | 1 | Flush the queue and restart fetching at redirect_addr_i |
| redirect_addr_i | input | AW | New fetch target |
| consume_i | input | $clog2(DEPTH+1) | Bytes the decoder takes from the head this cycle |
| req_valid_o | output | 1 | Chunk request raised |
| req_addr_o | output | AW | Byte address of the requested chunk |
| req_ready_i | input | 1 | Memory accepts the request this cycle |
| rsp_valid_i | input | 1 | A chunk returns, in request order |
| rsp_data_i | input | CHUNK×8 | Returned chunk, lowest address in bits 7..0 |
| win_bytes_o | output | DEPTH×8 | Aligned byte window, byte 0 in bits 7..0 |
| win_valid_o | output | DEPTH | Per-byte valid mask |
| win_addr_o | output | AW | Address of window byte 0 |

## Verification
The hardest case to reach is a redirect that arrives while several old-path chunks are still owed, sometimes with one of them landing in the same cycle. If such a chunk were wrongly kept, it would show up as window bytes whose values belong to the wrong address. The bench returns every chunk as a fixed function of its address, so any stale byte fails the window comparison. A storm phase raises redirects on about a third of cycles while responses come back late, which builds up several dropped chunks and presses against the total-outstanding limit. A separate sweep steps through every consume count 0–15 against the occupancies a full-speed refill produces, including counts that exceed the occupancy.

// File: rtl/ipq_pkg.sv
// Shared helpers for the instruction byte prefetch queue.
// Assumes callers widen counts to 8 bits before use.
package ipq_pkg;

    // Number of bytes that can actually leave: the request, capped by what is held.
    function automatic logic [7:0] clamp_take(logic [7:0] want, logic [7:0] have);
        return (want > have) ? have : want;
    endfunction

endpackage

// File: rtl/ipq_fetch_ctrl.sv
// Fetch-side control: keeps the next fetch address, counts chunks owed on the
// current path (live) and on abandoned paths (stale), and raises a request only
// when the buffer has space reserved for every live chunk plus the new one.
// Assumes responses come back in request order and never outnumber requests.
module ipq_fetch_ctrl #(
    parameter int            DEPTH      = 15,
    parameter int            CHUNK      = 4,
    parameter int            AW         = 32,
    parameter int            MAX_OUT    = 6,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int           CNTW       = $clog2(DEPTH + 1),
    localparam int           OW         = $clog2(MAX_OUT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect_i,
    input  logic [AW-1:0]   redirect_addr_i,
    input  logic [CNTW-1:0] occ_i,
    input  logic            req_ready_i,
    input  logic            rsp_valid_i,
    output logic            req_valid_o,
    output logic [AW-1:0]   req_addr_o,
    output logic            accept_o,
    output logic [OW-1:0]   live_o,
    output logic [OW-1:0]   stale_o
);
    localparam int SW = $clog2(DEPTH + CHUNK * (MAX_OUT + 1) + 1) + 1;

    logic [OW-1:0] live_q, stale_q;
    logic [AW-1:0] addr_q;
    logic [SW-1:0] need;
    logic          room, slots, fire, hit_stale;

    // Space and slot tests for issuing one more chunk request.
    assign need        = SW'(occ_i) + SW'(CHUNK) * (SW'(live_q) + SW'(1));
    assign room        = need <= SW'(DEPTH);
    assign slots       = (SW'(live_q) + SW'(stale_q)) < SW'(MAX_OUT);
    assign req_valid_o = !redirect_i && room && slots;
    assign fire        = req_valid_o && req_ready_i;
    assign hit_stale   = rsp_valid_i && (stale_q != '0);
    assign accept_o    = rsp_valid_i && !hit_stale && !redirect_i;
    assign req_addr_o  = addr_q;
    assign live_o      = live_q;
    assign stale_o     = stale_q;

    // Outstanding counters and fetch pointer; a redirect turns live chunks stale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= '0;
            stale_q <= '0;
            addr_q  <= RESET_ADDR;
        end else if (redirect_i) begin
            live_q  <= '0;
            stale_q <= stale_q + live_q - OW'(rsp_valid_i);
            addr_q  <= redirect_addr_i;
        end else begin
            live_q  <= live_q + OW'(fire) - OW'(rsp_valid_i && !hit_stale);
            stale_q <= stale_q - OW'(hit_stale);
            if (fire) begin
                addr_q <= addr_q + AW'(CHUNK);
            end
        end
    end

endmodule

// File: rtl/ipq_byte_buf.sv
// Byte storage: removes a clamped number of head bytes, shifts the rest to
// position zero and writes an accepted chunk straight after the leftovers.
// Assumes the fetch control has reserved room for any chunk it writes.
// Keeps every byte at or above the occupancy at zero.
module ipq_byte_buf #(
    parameter int            DEPTH      = 15,
    parameter int            CHUNK      = 4,
    parameter int            AW         = 32,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int           CNTW       = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               redirect_i,
    input  logic [AW-1:0]      redirect_addr_i,
    input  logic [CNTW-1:0]    consume_i,
    input  logic               wr_en_i,
    input  logic [CHUNK*8-1:0] wr_data_i,
    output logic [CNTW-1:0]    occ_o,
    output logic [AW-1:0]      base_addr_o,
    output logic [DEPTH*8-1:0] win_bytes_o,
    output logic [DEPTH-1:0]   win_valid_o
);
    import ipq_pkg::*;

    logic [DEPTH*8-1:0] data_q, shifted, nxt_bytes;
    logic [CNTW-1:0]    occ_q, eff, remaining, occ_nxt;
    logic [AW-1:0]      base_q;

    // Clamp the consume, drop the head bytes, and work out the new fill level.
    assign eff       = CNTW'(clamp_take(8'(consume_i), 8'(occ_q)));
    assign remaining = occ_q - eff;
    assign shifted   = data_q >> {eff, 3'b000};
    assign occ_nxt   = remaining + (wr_en_i ? CNTW'(CHUNK) : '0);

    // Per byte: take the chunk byte when it lands here, else the shifted byte.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [CNTW-1:0]    rel;
        logic               in_slot;
        logic [CHUNK*8-1:0] wr_sh;
        assign rel     = CNTW'(gi) - remaining;
        assign in_slot = wr_en_i && (CNTW'(gi) >= remaining) && (rel < CNTW'(CHUNK));
        assign wr_sh   = wr_data_i >> {rel, 3'b000};
        assign nxt_bytes[gi*8 +: 8] = in_slot ? wr_sh[7:0] : shifted[gi*8 +: 8];
        assign win_valid_o[gi]      = CNTW'(gi) < occ_q;
    end

    // Buffer state; a redirect clears contents and re-bases the head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            occ_q  <= '0;
            base_q <= RESET_ADDR;
        end else if (redirect_i) begin
            data_q <= '0;
            occ_q  <= '0;
            base_q <= redirect_addr_i;
        end else begin
            data_q <= nxt_bytes;
            occ_q  <= occ_nxt;
            base_q <= base_q + AW'(eff);
        end
    end

    assign occ_o       = occ_q;
    assign base_addr_o = base_q;
    assign win_bytes_o = data_q;

endmodule

// File: rtl/instr_prefetch_queue.sv
// Top of the instruction byte prefetch queue: joins the fetch control and the
// byte buffer. Assumes the decoder reads the window before it returns a count,
// and that the memory answers requests in order with whole chunks.
module instr_prefetch_queue #(
    parameter int            DEPTH      = 15,
    parameter int            CHUNK      = 4,
    parameter int            AW         = 32,
    parameter int            MAX_OUT    = 6,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int           CNTW       = $clog2(DEPTH + 1),
    localparam int           OW         = $clog2(MAX_OUT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               redirect_i,
    input  logic [AW-1:0]      redirect_addr_i,
    input  logic [CNTW-1:0]    consume_i,
    output logic               req_valid_o,
    output logic [AW-1:0]      req_addr_o,
    input  logic               req_ready_i,
    input  logic               rsp_valid_i,
    input  logic [CHUNK*8-1:0] rsp_data_i,
    output logic [DEPTH*8-1:0] win_bytes_o,
    output logic [DEPTH-1:0]   win_valid_o,
    output logic [AW-1:0]      win_addr_o
);
    logic [CNTW-1:0] occ;
    logic            accept;
    logic [OW-1:0]   live_cnt, stale_cnt;

    ipq_fetch_ctrl #(
        .DEPTH(DEPTH), .CHUNK(CHUNK), .AW(AW), .MAX_OUT(MAX_OUT), .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .redirect_i(redirect_i), .redirect_addr_i(redirect_addr_i),
        .occ_i(occ), .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i),
        .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
        .accept_o(accept), .live_o(live_cnt), .stale_o(stale_cnt)
    );

    ipq_byte_buf #(
        .DEPTH(DEPTH), .CHUNK(CHUNK), .AW(AW), .RESET_ADDR(RESET_ADDR)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .redirect_i(redirect_i), .redirect_addr_i(redirect_addr_i),
        .consume_i(consume_i), .wr_en_i(accept), .wr_data_i(rsp_data_i),
        .occ_o(occ), .base_addr_o(win_addr_o),
        .win_bytes_o(win_bytes_o), .win_valid_o(win_valid_o)
    );

endmodule

// File: rtl/instr_prefetch_queue_chk.sv
// Checker for the prefetch queue: relates window, request port and the
// outstanding counters across cycles. Attached to the top with bind.
module instr_prefetch_queue_chk #(
    parameter int  DEPTH   = 15,
    parameter int  CHUNK   = 4,
    parameter int  AW      = 32,
    parameter int  MAX_OUT = 6,
    localparam int CNTW    = $clog2(DEPTH + 1),
    localparam int OW      = $clog2(MAX_OUT + 1),
    localparam int SW      = $clog2(DEPTH + CHUNK * (MAX_OUT + 1) + 1) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             redirect_i,
    input logic [AW-1:0]    redirect_addr_i,
    input logic [CNTW-1:0]  consume_i,
    input logic             req_valid_o,
    input logic [AW-1:0]    req_addr_o,
    input logic             req_ready_i,
    input logic             rsp_valid_i,
    input logic [DEPTH-1:0] win_valid_o,
    input logic [AW-1:0]    win_addr_o,
    input logic             accept,
    input logic [OW-1:0]    live_cnt,
    input logic [OW-1:0]    stale_cnt
);
    logic [CNTW-1:0] occ, eff;
    assign occ = CNTW'($countones(win_valid_o));
    assign eff = (consume_i > occ) ? occ : consume_i;

    AST_VALID_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_o & (win_valid_o + 1'b1)) == '0); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_i |=> win_addr_o == $past(win_addr_o) + AW'($past(eff))); // R3
    AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_i && consume_i >= occ && !accept) |=> occ == '0); // R4
    AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_i |=> occ == $past(occ) - $past(eff) + ($past(accept) ? CNTW'(CHUNK) : '0)); // R5
    AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (SW'(occ) + SW'(CHUNK) * (SW'(live_cnt) + SW'(1)) <= SW'(DEPTH))
                        && (SW'(live_cnt) + SW'(stale_cnt) < SW'(MAX_OUT))); // R6
    AST_REQ_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=> req_addr_o == $past(req_addr_o) + AW'(CHUNK)); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> redirect_i || (req_valid_o && $stable(req_addr_o))); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (occ == '0) && (win_addr_o == $past(redirect_addr_i))
                       && (req_addr_o == $past(redirect_addr_i))); // R8
    AST_NO_REQ_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |-> !req_valid_o); // R8
    AST_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && stale_cnt != '0 && !redirect_i) |=> occ == $past(occ) - $past(eff)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        SW'(occ) + SW'(CHUNK) * SW'(live_cnt) <= SW'(DEPTH)); // R10

endmodule

bind instr_prefetch_queue instr_prefetch_queue_chk #(
    .DEPTH(DEPTH), .CHUNK(CHUNK), .AW(AW), .MAX_OUT(MAX_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .redirect_i(redirect_i), .redirect_addr_i(redirect_addr_i),
    .consume_i(consume_i), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
    .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i), .win_valid_o(win_valid_o),
    .win_addr_o(win_addr_o), .accept(accept), .live_cnt(live_cnt), .stale_cnt(stale_cnt)
);

// File: tb/sim_instr_prefetch_queue.sv
// Bench: memory returns each chunk as a fixed function of its address, so
// window bytes can be predicted from the head address alone.
module sim_instr_prefetch_queue;
    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 15;
    localparam int          CHUNK      = 4;
    localparam int          AW         = 32;
    localparam int          MAX_OUT    = 6;
    localparam logic [31:0] BOOT       = 32'h0000_1000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               redirect_i;
    logic [AW-1:0]      redirect_addr_i;
    logic [3:0]         consume_i;
    logic               req_valid_o;
    logic [AW-1:0]      req_addr_o;
    logic               req_ready_i;
    logic               rsp_valid_i;
    logic [CHUNK*8-1:0] rsp_data_i;
    logic [DEPTH*8-1:0] win_bytes_o;
    logic [DEPTH-1:0]   win_valid_o;
    logic [AW-1:0]      win_addr_o;

    instr_prefetch_queue #(
        .DEPTH(DEPTH), .CHUNK(CHUNK), .AW(AW), .MAX_OUT(MAX_OUT), .RESET_ADDR(BOOT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .redirect_i(redirect_i), .redirect_addr_i(redirect_addr_i),
        .consume_i(consume_i), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
        .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
        .win_bytes_o(win_bytes_o), .win_valid_o(win_valid_o), .win_addr_o(win_addr_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int e_cnt, e_live, e_stale, epoch;
    logic [31:0] e_addr, e_fetch;
    string occ_tag = "R5";
    logic [31:0] q_addr [16];
    int          q_ep   [16];
    int          q_due  [16];
    int          q_head = 0, q_n = 0;
    logic [31:0] rs = 32'h1234_5678;

    function automatic logic [7:0] mem_byte(logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    function automatic int unsigned rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // Compare window, mask, head address and occupancy with the model.
    task automatic check_window();
        logic [DEPTH-1:0] mask;
        mask = DEPTH'((32'd1 << e_cnt) - 1);
        chk(win_valid_o == mask, "R2", win_valid_o, mask);
        chk(win_addr_o == e_addr, "R3", win_addr_o, e_addr);
        chk($countones(win_valid_o) == e_cnt, occ_tag, $countones(win_valid_o), e_cnt);
        for (int k = 0; k < DEPTH; k++) begin
            if (k < e_cnt)
                chk(win_bytes_o[k*8 +: 8] == mem_byte(e_addr + 32'(k)), "R2",
                    win_bytes_o[k*8 +: 8], mem_byte(e_addr + 32'(k)));
            else
                chk(win_bytes_o[k*8 +: 8] == 8'h00, "R2", win_bytes_o[k*8 +: 8], 0);
        end
    endtask

    // One cycle: check outputs, drive inputs, predict request, advance model.
    task automatic step(input int cons, input bit redir, input logic [31:0] tgt,
                        input int rdy_pct, input int rsp_pct);
        bit rsp, acc, fire, exp_rv;
        int eff;
        @(negedge clk);
        cyc++;
        check_window();
        rsp = (q_n > 0) && (q_due[q_head] <= cyc) && ((rnd() % 100) < 32'(rsp_pct));
        consume_i       = 4'(cons);
        redirect_i      = redir;
        redirect_addr_i = tgt;
        req_ready_i     = (rnd() % 100) < 32'(rdy_pct);
        rsp_valid_i     = rsp;
        rsp_data_i      = '0;
        if (rsp)
            for (int b = 0; b < CHUNK; b++)
                rsp_data_i[b*8 +: 8] = mem_byte(q_addr[q_head] + 32'(b));
        #1;
        exp_rv = !redir && (e_cnt + CHUNK * (e_live + 1) <= DEPTH) && (e_live + e_stale < MAX_OUT);
        chk(req_valid_o == exp_rv, (redir ? "R8" : "R6"), req_valid_o, exp_rv);
        if (exp_rv) chk(req_addr_o == e_fetch, "R7", req_addr_o, e_fetch);
        fire = exp_rv && req_ready_i;
        acc  = rsp && (q_ep[q_head] == epoch) && !redir;
        eff  = (cons > e_cnt) ? e_cnt : cons;
        occ_tag = "R5";
        if (redir) begin
            e_stale = e_stale + e_live - (rsp ? 1 : 0);
            e_live  = 0;
            e_cnt   = 0;
            e_addr  = tgt;
            e_fetch = tgt;
            epoch++;
            occ_tag = rsp ? "R9" : "R8";
        end else begin
            if (rsp) begin
                if (q_ep[q_head] == epoch) e_live--;
                else begin e_stale--; occ_tag = "R9"; end
            end
            if (cons > e_cnt) occ_tag = "R4";
            e_cnt  = e_cnt - eff + (acc ? CHUNK : 0);
            chk(e_cnt <= DEPTH, "R10", e_cnt, DEPTH);
            e_addr = e_addr + 32'(eff);
            if (fire) begin
                q_addr[(q_head + q_n) % 16] = e_fetch;
                q_ep[(q_head + q_n) % 16]   = epoch;
                q_due[(q_head + q_n) % 16]  = cyc + 1 + int'(rnd() % 3);
                q_n++;
                e_live++;
                e_fetch = e_fetch + CHUNK;
            end
        end
        if (rsp) begin
            q_head = (q_head + 1) % 16;
            q_n--;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        redirect_i = 1'b0; redirect_addr_i = '0; consume_i = '0;
        req_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_data_i = '0;
        e_cnt = 0; e_live = 0; e_stale = 0; epoch = 0;
        e_addr = BOOT; e_fetch = BOOT;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk(win_valid_o == '0, "R1", win_valid_o, 0);
        chk(win_addr_o == BOOT, "R1", win_addr_o, BOOT);
        chk(req_addr_o == BOOT, "R1", req_addr_o, BOOT);
        rst_n = 1'b1;
        // Fill at full speed: ends at 12 bytes held, no room for a fourth chunk (R10).
        for (int i = 0; i < 20; i++) step(0, 1'b0, 32'h0, 100, 100);
        chk(e_cnt == 12, "R10", e_cnt, 12);
        // Sweep every consume count against the occupancies refill produces (R3, R4).
        for (int c = 0; c < 16; c++)
            for (int r = 0; r < 6; r++) step(c, 1'b0, 32'h0, 100, 100);
        // Memory stalls: pending request must hold (R7).
        for (int i = 0; i < 30; i++) step(int'(rnd() % 3), 1'b0, 32'h0, 0, 100);
        // Mixed traffic with occasional redirects to arbitrary byte addresses (R8).
        for (int i = 0; i < 3000; i++)
            step(int'(rnd() % 16), (rnd() % 20) == 0, rnd() & 32'h0000_FFFF, 70, 60);
        // Redirect storm with slow responses builds up stale chunks (R9).
        for (int i = 0; i < 400; i++)
            step(int'(rnd() % 16), (rnd() % 3) == 0, rnd() & 32'h0000_FFFF, 90, 40);
        // Drain.
        for (int i = 0; i < 40; i++) step(int'(rnd() % 5), 1'b0, 32'h0, 80, 100);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule